// File: doc/BRIEF.md
# UART Receiver with Error Detection

This block takes an asynchronous serial line and turns it back into characters. A programmable 16-bit divisor produces a tick at sixteen times the baud rate. While the receiver is idle it watches the line on every tick. When it sees the line low, it waits half a bit period to confirm the start bit. After that it samples each later bit once per full bit period, which places every sample near the middle of its bit.

The word length can be 5 to 8 bits, and software chooses it at run time. Parity can be off, even, odd, or forced to a fixed value. Each completed character is written to a data register and raises a data-ready flag. The same update reports that character's parity result, its stop-bit result, and whether unread data was lost. A read strobe clears all four flags.

Top module: `uart_rx_core`

## Requirements
- R1: An idle line is high. In idle, a tick that samples the line low starts a frame. The frame is accepted only if the line is still low on the 8th tick after that. Otherwise the receiver returns to idle and reports no character.
- R2: The oversampling tick comes once every `divisor` clock cycles, for any divisor from 1 to 65535. A divisor of 0 behaves like 1.
- R3: Data bits are taken least significant bit first. Each one is sampled 16 ticks after the previous sample. The count comes from `word_len`: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits of `rx_data` above the word length read 0.
- R4: When `par_en` is 1, one parity bit follows the data bits and `parity_err` shows whether it was wrong. The expected value depends on the settings. With `par_stick`=1 it is 0 if `par_even` is 1, and 1 if `par_even` is 0. Otherwise, even parity (`par_even`=1) expects the XOR of the data bits, and odd parity expects its inverse. When `par_en` is 0, `parity_err` is 0 for that character.
- R5: `frame_err` is set for a character whose first stop sample is low. Only that one stop sample is checked. On the next tick after it, the receiver is looking for a new start bit.
- R6: Each completed character loads `rx_data` and sets `data_ready`. The new character's own parity and framing results replace the previous flags.
- R7: A character that completes while `data_ready` is 1, with no read strobe in that cycle, sets `overrun`. The newer character replaces the older one.
- R8: `rd_stb` clears `data_ready`, `parity_err`, `frame_err` and `overrun`. If a character completes in the same cycle, the new character's flags take effect and `overrun` is 0.
- R9: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_in | input | 1 | Serial line, already synchronous to clk |
| divisor | input | 16 | Clock cycles per oversampling tick |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select, also picks the stick value |
| par_stick | input | 1 | Parity bit forced to a fixed value |
| rd_stb | input | 1 | Read strobe, clears the status flags |
| rx_data | output | 8 | Last received character, zero-extended |
| data_ready | output | 1 | Unread character present |
| parity_err | output | 1 | Parity error on the last character |
| frame_err | output | 1 | Stop-bit error on the last character |
| overrun | output | 1 | Unread character was overwritten |

## Verification
The assertions assume two things about the inputs. First, `rx_in` is already synchronous to the clock. Second, the divisor, word length and parity settings stay constant while a frame is being received. The bench keeps to both conditions. It drives the line and the settings only on falling clock edges. It changes the settings only while the line is idle and no frame is in progress. The stop bit in the framing-error case is kept short. Because of that, the low line after the bad stop bit is rejected as a start bit and does not produce a spurious character.

// File: rtl/uart_rx_pkg.sv
// Package: shared constants and the frame sequencer state type.
// Assumes a 16x oversampling receiver.
package uart_rx_pkg;
    localparam int OSR      = 16;   // ticks per bit
    localparam int HALF_OSR = 8;    // ticks from start detect to start mid-point
    localparam int MIN_BITS = 5;    // word length for code 00

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/uart_rx_baud.sv
// Module: free-running oversample tick generator.
// Outputs a one-cycle tick every 'divisor' clocks.
// Assumes: a divisor of 0 is handled like 1.
module uart_rx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    // Terminal count, with 0 mapped to 1.
    always_comb lim = (divisor == '0) ? '0 : divisor - 1'b1;

    assign tick = (cnt >= lim);

    // Cycle counter that wraps on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && divisor > 16'd1) |=> (!tick || divisor <= 16'd1)); // R2
endmodule

// File: rtl/uart_rx_parchk.sv
// Module: combinational parity checker.
// Compares the received parity bit with the expected value.
// Assumes: unused upper data bits are zero.
module uart_rx_parchk #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              pbit,
    input  logic              en,
    input  logic              even,
    input  logic              stick,
    output logic              err
);
    logic expect_bit;

    // Work out the expected parity bit for the selected mode.
    always_comb begin
        if (stick)     expect_bit = ~even;
        else if (even) expect_bit = ^data;
        else           expect_bit = ~(^data);
        err = en && (pbit != expect_bit);
    end
endmodule

// File: rtl/uart_rx_frame.sv
// Module: frame sequencer.
// Confirms the start bit, samples the data bits, the parity bit and the first stop bit.
// 'done' pulses on the tick that samples the stop bit.
// Assumes: rx_in is synchronous, and the settings are stable during a frame.
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_in,
    input  logic [1:0]        word_len,
    input  logic              par_en,
    output logic              done,
    output logic              stop_bit,
    output logic              par_bit,
    output logic [DATA_W-1:0] data
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] FULL_END = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] HALF_END = CNT_W'(HALF_OSR - 1);

    rx_state_e        state;
    logic [CNT_W-1:0] tcnt;
    logic [IDX_W-1:0] bidx;
    logic [IDX_W-1:0] last_idx;
    logic [DATA_W-1:0] shreg;

    // Index of the final data bit for the chosen word length.
    always_comb last_idx = IDX_W'(word_len) + IDX_W'(MIN_BITS - 1);

    // Step through the frame on each oversample tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            tcnt    <= '0;
            bidx    <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
        end else if (tick) begin
            case (state)
                RX_IDLE: begin
                    if (!rx_in) begin
                        state <= RX_START;
                        tcnt  <= '0;
                    end
                end
                RX_START: begin
                    if (tcnt == HALF_END) begin
                        tcnt <= '0;
                        if (!rx_in) begin
                            state <= RX_DATA;
                            bidx  <= '0;
                            shreg <= '0;
                        end else begin
                            state <= RX_IDLE;
                        end
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (tcnt == FULL_END) begin
                        tcnt        <= '0;
                        shreg[bidx] <= rx_in;
                        if (bidx == last_idx) state <= par_en ? RX_PAR : RX_STOP;
                        else                  bidx  <= bidx + 1'b1;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (tcnt == FULL_END) begin
                        tcnt    <= '0;
                        par_bit <= rx_in;
                        state   <= RX_STOP;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (tcnt == FULL_END) begin
                        tcnt  <= '0;
                        state <= RX_IDLE;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign done     = tick && (state == RX_STOP) && (tcnt == FULL_END);
    assign stop_bit = rx_in;
    assign data     = shreg;

    AST_START_CONFIRMED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_DATA && $past(state) == RX_START) |-> !$past(rx_in)); // R1
    AST_BIDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_DATA) |-> (bidx <= last_idx)); // R3
    AST_DONE_LEAVES_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state == RX_IDLE)); // R5
endmodule

// File: rtl/uart_rx_core.sv
// Module: top of the receiver.
// Holds the received data register and the four status flags, and updates them
// when a frame completes or the read strobe arrives.
// Assumes: rx_in is synchronous to clk.
module uart_rx_core #(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [1:0]        word_len,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              par_stick,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rx_data,
    output logic              data_ready,
    output logic              parity_err,
    output logic              frame_err,
    output logic              overrun
);
    logic              tick;
    logic              frm_done;
    logic              frm_stop;
    logic              frm_pbit;
    logic [DATA_W-1:0] frm_data;
    logic              pe_new;

    uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
    );

    uart_rx_frame #(.DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx_in),
        .word_len(word_len), .par_en(par_en), .done(frm_done),
        .stop_bit(frm_stop), .par_bit(frm_pbit), .data(frm_data)
    );

    uart_rx_parchk #(.DATA_W(DATA_W)) u_par (
        .data(frm_data), .pbit(frm_pbit), .en(par_en),
        .even(par_even), .stick(par_stick), .err(pe_new)
    );

    // Load a completed character, or clear the flags on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data    <= '0;
            data_ready <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
            overrun    <= 1'b0;
        end else if (frm_done) begin
            rx_data    <= frm_data;
            data_ready <= 1'b1;
            parity_err <= pe_new;
            frame_err  <= ~frm_stop;
            overrun    <= data_ready && !rd_stb;
        end else if (rd_stb) begin
            data_ready <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
            overrun    <= 1'b0;
        end
    end

    AST_NEW_CHAR_READY: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |=> data_ready); // R6
    AST_OVR_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> data_ready); // R7
    AST_OVR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(data_ready)); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !frm_done) |=> (!data_ready && !overrun)); // R8
endmodule

// File: tb/uart_rx_core_bench.sv
// Bench: a behavioural reference model is compared with the outputs on every clock.
// Directed checks follow each scenario.
module uart_rx_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_in = 1'b1;
    logic [15:0] divisor = 16'd1;
    logic [1:0]  word_len = 2'd3;
    logic        par_en = 1'b0;
    logic        par_even = 1'b0;
    logic        par_stick = 1'b0;
    logic        rd_stb = 1'b0;
    logic [7:0]  rx_data;
    logic        data_ready, parity_err, frame_err, overrun;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    uart_rx_core u_uart_rx_core (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .divisor(divisor),
        .word_len(word_len), .par_en(par_en), .par_even(par_even),
        .par_stick(par_stick), .rd_stb(rd_stb), .rx_data(rx_data),
        .data_ready(data_ready), .parity_err(parity_err),
        .frame_err(frame_err), .overrun(overrun)
    );

    function automatic logic exp_par(logic [7:0] d, logic even, logic stick);
        int ones = $countones(d);
        if (stick) return !even;
        return even ? logic'(ones % 2) : logic'(!(ones % 2));
    endfunction

    // Reference model: counts ticks since the start detect.
    int         m_div = 0;
    bit         m_busy = 0;
    int         m_k = 0;
    logic [7:0] m_sh = '0;
    logic       m_pbit = 0;
    logic [7:0] e_data = '0;
    logic       e_rdy = 0, e_pe = 0, e_fe = 0, e_ovr = 0;

    always @(posedge clk) begin
        int  lim;
        int  nb;
        int  idx;
        bit  mtick;
        bit  cmp;
        logic stopv;
        cmp = 0;
        stopv = 1'b1;
        if (!rst_n) begin
            m_div = 0; m_busy = 0; m_k = 0; m_sh = '0; m_pbit = 0;
            e_data = '0; e_rdy = 0; e_pe = 0; e_fe = 0; e_ovr = 0;
        end else begin
            lim   = (divisor == 0) ? 0 : int'(divisor) - 1;
            mtick = (m_div >= lim);
            m_div = mtick ? 0 : m_div + 1;
            nb    = int'(word_len) + 5;
            if (mtick) begin
                if (!m_busy) begin
                    if (!rx_in) begin m_busy = 1; m_k = 0; end
                end else begin
                    m_k++;
                    if (m_k == 8) begin
                        if (rx_in) m_busy = 0;
                        else m_sh = '0;
                    end else if (m_k > 8 && (m_k - 8) % 16 == 0) begin
                        idx = (m_k - 8) / 16 - 1;
                        if (idx < nb) m_sh[idx] = rx_in;
                        else if (par_en && idx == nb) m_pbit = rx_in;
                        else begin cmp = 1; stopv = rx_in; m_busy = 0; end
                    end
                end
            end
            if (cmp) begin
                e_ovr  = e_rdy && !rd_stb;
                e_rdy  = 1;
                e_data = m_sh;
                e_pe   = par_en && (m_pbit != exp_par(m_sh, par_even, par_stick));
                e_fe   = !stopv;
            end else if (rd_stb) begin
                e_rdy = 0; e_pe = 0; e_fe = 0; e_ovr = 0;
            end
        end
    end

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        cycles++;
        checks++;
        if (rx_data !== e_data || data_ready !== e_rdy || parity_err !== e_pe ||
            frame_err !== e_fe || overrun !== e_ovr) begin
            errors++;
            $display("FAIL R3/R4/R5/R6/R7 model compare t=%0t act=%h/%b%b%b%b exp=%h/%b%b%b%b",
                     $time, rx_data, data_ready, parity_err, frame_err, overrun,
                     e_data, e_rdy, e_pe, e_fe, e_ovr);
        end
    end

    // Watchdog: a run that hangs counts as a failed check.
    initial begin
        wait (cycles > 150000);
        checks++;
        errors++;
        $display("FAIL watchdog act=%0d exp<150000 cycles", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic hold(logic v, int cyc);
        rx_in = v;
        repeat (cyc) @(negedge clk);
    endtask

    // Send one frame: per = cycles per bit; parity bit is sent when has_par is set.
    task automatic send(logic [7:0] d, int nb, bit has_par, logic pv, logic stopv, int per);
        hold(1'b0, per);
        for (int i = 0; i < nb; i++) hold(d[i], per);
        if (has_par) hold(pv, per);
        hold(stopv, stopv ? per : (per * 10) / 16);
        rx_in = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_flags();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9", "data_ready after reset", data_ready, 0);
        chk("R9", "rx_data after reset", rx_data, 0);
        chk("R9", "flags after reset", {parity_err, frame_err, overrun}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R3 R6: 8 data bits, no parity, divisor 1
        send(8'hA5, 8, 0, 0, 1, 16);
        chk("R3", "8-bit data", rx_data, 8'hA5);
        chk("R6", "data_ready set", data_ready, 1);
        chk("R5", "no framing error", frame_err, 0);
        read_flags();
        chk("R8", "read clears ready", data_ready, 0);

        // R4: 5 bits, even parity, correct parity bit
        word_len = 2'd0; par_en = 1; par_even = 1;
        send(8'h13, 5, 1, exp_par(8'h13, 1, 0), 1, 16);
        chk("R3", "5-bit data", rx_data, 8'h13);
        chk("R4", "good even parity", parity_err, 0);
        read_flags();
        // R4: wrong parity bit
        send(8'h13, 5, 1, !exp_par(8'h13, 1, 0), 1, 16);
        chk("R4", "bad even parity flagged", parity_err, 1);
        // R7: new character while unread
        send(8'h0A, 5, 1, exp_par(8'h0A, 1, 0), 1, 16);
        chk("R7", "overrun set", overrun, 1);
        chk("R7", "newer data kept", rx_data, 8'h0A);
        chk("R6", "per-character parity replaced", parity_err, 0);
        read_flags();
        chk("R8", "read clears overrun", overrun, 0);

        // R5: low stop bit
        word_len = 2'd3; par_en = 0;
        send(8'h3C, 8, 0, 0, 0, 16);
        repeat (40) @(negedge clk);
        chk("R5", "framing error flagged", frame_err, 1);
        chk("R5", "data with bad stop", rx_data, 8'h3C);
        read_flags();
        chk("R8", "read clears framing error", frame_err, 0);

        // R1: short low pulse is rejected
        hold(1'b0, 4);
        hold(1'b1, 300);
        chk("R1", "glitch gives no character", data_ready, 0);

        // R4: stick parity, even select expects 0
        par_en = 1; par_stick = 1; par_even = 1;
        send(8'h81, 8, 1, 1, 1, 16);
        chk("R4", "stick parity mismatch", parity_err, 1);
        read_flags();
        send(8'h81, 8, 1, 0, 1, 16);
        chk("R4", "stick parity match", parity_err, 0);
        read_flags();

        // R2: divisor 3, 7 bits, odd parity
        divisor = 16'd3; word_len = 2'd2; par_stick = 0; par_even = 0;
        send(8'h55, 7, 1, exp_par(8'h55, 0, 0), 1, 48);
        chk("R2", "divisor 3 data", rx_data, 8'h55);
        chk("R4", "good odd parity", parity_err, 0);
        read_flags();
        // R3: upper bits zero for 6-bit word
        word_len = 2'd1; par_en = 0;
        send(8'hFF, 6, 0, 0, 1, 48);
        chk("R3", "6-bit zero-extended", rx_data, 8'h3F);
        read_flags();

        // R2 R5: divisor 0 acts as 1, back-to-back frames rearm after one stop bit
        divisor = 16'd0; word_len = 2'd3;
        hold(1'b0, 16);
        for (int i = 0; i < 8; i++) hold(logic'((8'h11 >> i) & 1), 16);
        hold(1'b1, 16);
        send(8'hEE, 8, 0, 0, 1, 16);
        chk("R5", "back-to-back second char", rx_data, 8'hEE);
        chk("R7", "back-to-back overrun", overrun, 1);
        read_flags();
        chk("R8", "all flags clear", {data_ready, parity_err, frame_err, overrun}, 0);

        repeat (10) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule